// File: doc/BRIEF.md
# External interrupt input controller

This block watches four maskable interrupt pins and one non-maskable pin. Each pin first passes through a synchroniser. A detector then turns a chosen edge, or a level in one case, into a request that sets a sticky pending flag for that source. Software sets the trigger rules through a write-only mode register. It clears one flag at a time by writing that source's vector code to a write-only clear register. The CPU can also clear a flag by presenting the same code on an acknowledge port when it takes the interrupt.

The pending flags feed a priority and masking stage that lies outside this block. Each maskable pin has its own edge polarity. Source 0 can instead be level-triggered. The non-maskable pin triggers on a falling edge by default and can be switched to trigger on both edges.

Top module: `xirq_ctrl`

## Requirements
- R1: While reset is high, all five pending flags clear on each clock edge. The mode register returns to all zeros, which selects rising edges, edge mode for source 0 and a non-maskable trigger on the falling edge only.
- R2: A pin change applied between clock edges appears on its pending flag after the third rising clock edge, and not after the second.
- R3: The mode register is written at address 0x8C. Data bits 2, 3, 4 and 5 select the polarity of sources 0, 1, 2 and 3. A value of 0 sets the flag on a rising edge and 1 on a falling edge. The opposite edge sets nothing.
- R4: A write to the mode register with data bit 7 or bit 6 set is discarded, and the previous mode is kept.
- R5: Writes to any address other than 0x8C or 0x88 change neither the mode nor any flag.
- R6: With mode bit 1 set, source 0 is level-triggered. A high synchronised level sets its flag, and a low level sets nothing.
- R7: In level mode, a clear of source 0 takes effect for one cycle. If the pin is still high, the flag is set again on the following edge.
- R8: With mode bit 0 at 0, the non-maskable flag is set only by a falling edge. With bit 0 at 1, both edges set it.
- R9: Writing a full data byte to address 0x88 clears exactly one flag when the byte equals that source's code. The codes are 0x0A for source 0, 0x0B for source 1, 0x0C for source 2, 0x0D for source 3 and 0x08 for the non-maskable source. Any other byte, including one with bits 7 or 6 set, clears nothing.
- R10: A cycle with the acknowledge strobe high clears the flag whose code equals the 6-bit acknowledge code, using the same codes as R9.
- R11: For an edge-triggered source, a new edge detected in the same cycle as its clear leaves the flag set.
- R12: In edge mode a flag stays set after the pin returns to its idle level, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| ack_en | input | 1 | Interrupt acknowledge strobe |
| ack_code | input | 6 | Vector code of the acknowledged source |
| irq_pin | input | 4 | Maskable interrupt pins, asynchronous |
| nmi_pin | input | 1 | Non-maskable interrupt pin, asynchronous |
| irq_pend | output | 4 | Pending flags of the maskable sources |
| nmi_pend | output | 1 | Pending flag of the non-maskable source |

## Verification
The bench covers every pair of maskable source and polarity with a rising and then a falling pin transition. This separates correct edge selection from swapped polarity bits and from sources whose bits are misrouted to another flag. The non-maskable pin is tried in both of its modes with both transitions, which separates falling-only triggering from both-edge triggering. Targeted sequences line up a clear with a new edge in the same cycle, and clear a level-mode source while its pin stays high, to separate set-wins behaviour from clear-wins behaviour. Wrong codes, reserved bits and foreign addresses check that writes are decoded against the full byte.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam logic [7:0] CODE_SRC_BASE = 8'h0A;
  localparam logic [7:0] CODE_NMI      = 8'h08;

  // Vector code of source idx; indices at or above n_int denote the NMI.
  function automatic logic [7:0] src_code(input int idx, input int n_int);
    if (idx >= n_int) return CODE_NMI;
    return CODE_SRC_BASE + 8'(idx);
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_lane
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din[g]};
      end
      assign dout[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect #(
  parameter int N_INT = 4,
  localparam int NSRC = N_INT + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  lvl,
  input  logic [N_INT-1:0] fall_sel,
  input  logic             lvl0_mode,
  input  logic             nmi_both,
  output logic [NSRC-1:0]  prev,
  output logic [NSRC-1:0]  req
);
  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  genvar g;
  generate
    for (g = 0; g < N_INT; g++) begin : g_src
      logic rise, fall;
      assign rise = lvl[g] & ~prev[g];
      assign fall = ~lvl[g] & prev[g];
      if (g == 0) begin : g_lvl_capable
        assign req[g] = lvl0_mode ? lvl[g] : (fall_sel[g] ? fall : rise);
      end else begin : g_edge_only
        assign req[g] = fall_sel[g] ? fall : rise;
      end
    end
  endgenerate

  assign req[N_INT] = nmi_both ? (lvl[N_INT] ^ prev[N_INT])
                               : (prev[N_INT] & ~lvl[N_INT]);
endmodule

// File: rtl/xirq_flags.sv
module xirq_flags #(
  parameter int N_INT = 4,
  localparam int NSRC = N_INT + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] clr,
  input  logic            lvl0_mode,
  output logic [NSRC-1:0] pend
);
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_flag
      logic nxt;
      if (g == 0) begin : g_mixed
        // level mode: clear wins this cycle, level re-sets on the next
        assign nxt = lvl0_mode ? (~clr[g] & (pend[g] | req[g]))
                               : (req[g] | (pend[g] & ~clr[g]));
      end else begin : g_edge
        assign nxt = req[g] | (pend[g] & ~clr[g]);
      end
      always_ff @(posedge clk) begin
        if (rst) pend[g] <= 1'b0;
        else     pend[g] <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl #(
  parameter int          N_INT     = 4,
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter int          CODE_W    = 6,
  parameter int          SYNC_STG  = 2,
  parameter logic [7:0]  MODE_ADDR = 8'h8C,
  parameter logic [7:0]  CLR_ADDR  = 8'h88
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ack_en,
  input  logic [CODE_W-1:0] ack_code,
  input  logic [N_INT-1:0]  irq_pin,
  input  logic              nmi_pin,
  output logic [N_INT-1:0]  irq_pend,
  output logic              nmi_pend
);
  import xirq_pkg::*;

  localparam int NSRC    = N_INT + 1;
  localparam int MODE_HI = N_INT + 2;

  logic [N_INT-1:0] fall_sel_q;
  logic             lvl0_q;
  logic             nmi_both_q;
  logic             mode_wr, clr_wr;
  logic [NSRC-1:0]  s_pins, prev_pins, req, clr, pend_all;

  assign mode_wr = wr_en && (wr_addr == ADDR_W'(MODE_ADDR))
                   && (wr_data[DATA_W-1:MODE_HI] == '0);
  assign clr_wr  = wr_en && (wr_addr == ADDR_W'(CLR_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_sel_q <= '0;
      lvl0_q     <= 1'b0;
      nmi_both_q <= 1'b0;
    end else if (mode_wr) begin
      fall_sel_q <= wr_data[2 +: N_INT];
      lvl0_q     <= wr_data[1];
      nmi_both_q <= wr_data[0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_clr
      localparam logic [7:0] CODE = src_code(g, N_INT);
      assign clr[g] = (clr_wr && (wr_data == DATA_W'(CODE)))
                    || (ack_en && ({2'b00, ack_code} == 8'(CODE)));
    end
  endgenerate

  xirq_sync #(.WIDTH(NSRC), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({nmi_pin, irq_pin}),
    .dout(s_pins)
  );

  xirq_detect #(.N_INT(N_INT)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .lvl      (s_pins),
    .fall_sel (fall_sel_q),
    .lvl0_mode(lvl0_q),
    .nmi_both (nmi_both_q),
    .prev     (prev_pins),
    .req      (req)
  );

  xirq_flags #(.N_INT(N_INT)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .clr      (clr),
    .lvl0_mode(lvl0_q),
    .pend     (pend_all)
  );

  assign irq_pend = pend_all[N_INT-1:0];
  assign nmi_pend = pend_all[N_INT];
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk #(
  parameter int N_INT = 4,
  localparam int NSRC = N_INT + 1
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] s,
  input logic [NSRC-1:0] prev,
  input logic [NSRC-1:0] req,
  input logic [NSRC-1:0] clr,
  input logic            lvl0,
  input logic [NSRC-1:0] pend
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pend == '0));

  a_r8_nmi_needs_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(pend[N_INT]) |-> $past(s[N_INT] != prev[N_INT]));

  a_r11_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (req[N_INT:1] != '0) |=>
      ((pend[N_INT:1] & $past(req[N_INT:1])) == $past(req[N_INT:1])));

  a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
    ((clr[N_INT:1] & ~req[N_INT:1]) != '0) |=>
      ((pend[N_INT:1] & $past(clr[N_INT:1] & ~req[N_INT:1])) == '0));

  a_r7_level_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (lvl0 && clr[0]) |=> !pend[0]);

  a_r6_level_sets: assert property (@(posedge clk) disable iff (rst)
    (lvl0 && s[0] && !clr[0]) |=> pend[0]);
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.N_INT(N_INT)) u_chk (
  .clk (clk),
  .rst (rst),
  .s   (s_pins),
  .prev(prev_pins),
  .req (req),
  .clr (clr),
  .lvl0(lvl0_q),
  .pend(pend_all)
);

// File: tb/xirq_ctrl_test.sv
`timescale 1ns/1ps
module xirq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ack_en = 1'b0;
  logic [5:0] ack_code = '0;
  logic [3:0] irq_pin = '0;
  logic       nmi_pin = 1'b0;
  logic [3:0] irq_pend;
  logic       nmi_pend;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #2.5 clk = ~clk;

  xirq_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack_en(ack_en), .ack_code(ack_code), .irq_pin(irq_pin), .nmi_pin(nmi_pin),
    .irq_pend(irq_pend), .nmi_pend(nmi_pend)
  );

  function automatic logic [7:0] code_of(input int idx);
    return (idx >= 4) ? 8'h08 : 8'h0A + 8'(idx);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ack(input logic [5:0] c);
    ack_en = 1'b1; ack_code = c;
    @(negedge clk);
    ack_en = 1'b0;
  endtask

  task automatic clear_all();
    for (int k = 0; k < 5; k++) wr(8'h88, code_of(k));
  endtask

  task automatic chk(input string r, input logic [4:0] exp);
    logic [4:0] got;
    got = {nmi_pend, irq_pend};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", r, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(4);
    chk("R1", 5'b00000);
    rst = 1'b0;
    tick(2);
    chk("R1", 5'b00000);

    // R2 latency, R12 sticky, default rising edge
    irq_pin[1] = 1'b1;
    tick(2); chk("R2", 5'b00000);
    tick(1); chk("R2", 5'b00010);
    irq_pin[1] = 1'b0;
    tick(4); chk("R12", 5'b00010);
    wr(8'h88, 8'h0F); chk("R9", 5'b00010);
    wr(8'h88, 8'hCB); chk("R9", 5'b00010);
    wr(8'h88, 8'h0B); chk("R9", 5'b00000);

    // R3 sweep: every source, both polarities, both transitions
    for (int pol = 0; pol < 2; pol++) begin
      for (int i = 0; i < 4; i++) begin
        wr(8'h8C, 8'(pol << (2 + i)));
        tick(4);
        clear_all();
        irq_pin[i] = 1'b1;
        tick(4);
        chk("R3", (pol == 0) ? 5'(1 << i) : 5'b00000);
        wr(8'h88, code_of(i));
        chk("R9", 5'b00000);
        irq_pin[i] = 1'b0;
        tick(4);
        chk("R3", (pol == 1) ? 5'(1 << i) : 5'b00000);
        clear_all();
      end
    end

    // R4 reserved bits reject the write
    wr(8'h8C, 8'h3C);
    wr(8'h8C, 8'hC0);
    irq_pin[0] = 1'b1; tick(4);
    chk("R4", 5'b00000);
    irq_pin[0] = 1'b0; tick(4);
    chk("R4", 5'b00001);
    clear_all();

    // R5 foreign address ignored
    wr(8'h8C, 8'h00);
    wr(8'h8D, 8'h3C);
    wr(8'h89, 8'h0D);
    irq_pin[3] = 1'b1; tick(4);
    chk("R5", 5'b01000);
    wr(8'h8A, 8'h0D);
    chk("R5", 5'b01000);
    irq_pin[3] = 1'b0; tick(4);

    // R10 acknowledge port
    ack(6'h0A); chk("R10", 5'b01000);
    ack(6'h0D); chk("R10", 5'b00000);

    // R11 edge coincident with clear keeps the flag
    irq_pin[3] = 1'b1; tick(4);
    irq_pin[3] = 1'b0; tick(4);
    chk("R11", 5'b01000);
    irq_pin[3] = 1'b1;
    tick(2);
    wr(8'h88, 8'h0D);
    chk("R11", 5'b01000);
    tick(1); chk("R11", 5'b01000);
    wr(8'h88, 8'h0D); chk("R11", 5'b00000);
    irq_pin[3] = 1'b0; tick(4);

    // R8 NMI falling only, then both edges
    nmi_pin = 1'b1; tick(4); chk("R8", 5'b00000);
    nmi_pin = 1'b0; tick(4); chk("R8", 5'b10000);
    wr(8'h88, 8'h08); chk("R8", 5'b00000);
    wr(8'h8C, 8'h01);
    nmi_pin = 1'b1; tick(4); chk("R8", 5'b10000);
    wr(8'h88, 8'h08); chk("R8", 5'b00000);
    nmi_pin = 1'b0; tick(4); chk("R8", 5'b10000);
    ack(6'h08); chk("R10", 5'b00000);

    // R6/R7 level mode on source 0
    wr(8'h8C, 8'h02);
    tick(3); chk("R6", 5'b00000);
    irq_pin[0] = 1'b1; tick(4); chk("R6", 5'b00001);
    wr(8'h88, 8'h0A); chk("R7", 5'b00000);
    tick(1); chk("R7", 5'b00001);
    irq_pin[0] = 1'b0; tick(4);
    wr(8'h88, 8'h0A); chk("R7", 5'b00000);
    tick(3); chk("R6", 5'b00000);

    // R1 reset again restores default mode
    rst = 1'b1; tick(2); rst = 1'b0;
    chk("R1", 5'b00000);
    irq_pin[0] = 1'b1; tick(4); chk("R1", 5'b00001);
    irq_pin[0] = 1'b0; tick(4);
    wr(8'h88, 8'h0A); chk("R1", 5'b00000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule